// File: doc/BRIEF.md
# Flash Bank and Charge-Pump Power Sequencer

This block decides the power state of a set of flash banks and of the one charge pump that they share. Each bank runs an idle timer that restarts on every access. Once a bank has stayed idle for the programmed grace period, it drops to the fall-back state chosen for it: standby or sleep. A bank whose fall-back is active never leaves the active state. When every bank is asleep and the pump's fall-back is sleep, the pump also goes to sleep.

Coming back up is done in fixed stages. A wake request, or an access to a sleeping bank, first wakes the pump. Only after the pump is active does a sleeping bank step to standby and then to active. Each stage lasts a fixed number of cycles set by a parameter, which stands in for the analog settling times. An access to a bank that is not active raises that bank's wait flag. The flag stays high until the bank is active again. The ready output says whether the flash can serve the CPU.

A wake request that arrives while banks are still counting down toward a low-power state cancels the entry. The request stays latched until the whole flash is ready.

Top module: `flash_pwr_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, every bank reads active, the pump reads active, ready is 1 and every wait flag is 0. Bank state codes are 0 active, 1 standby, 2 sleep, 3 sleep-to-standby, 4 standby-to-active. Pump state codes are 0 active, 1 sleep, 2 waking.
- R2: An active bank whose fall-back is standby (code 1) or sleep (codes 2 or 3) moves to that state on the (G+1)-th consecutive clock edge with no access and no wake. G is the grace input. With G = 0 the bank moves on the first idle edge.
- R3: An access to an active bank reloads its idle count. A bank whose fall-back code is 0 stays active however long it is idle.
- R4: The pump goes from active to sleep one edge after every bank reads sleep, provided the pump fall-back input is 1 and no wake is outstanding. While any bank is not asleep, the pump stays active.
- R5: A wake request, or an access to a sleeping bank, moves a sleeping pump to waking. It stays waking for T_PUMP cycles and then becomes active. No bank leaves sleep before the pump reads active.
- R6: A sleeping bank with a pending wake leaves sleep on the first edge at which the pump reads active. It then spends T_S2SB cycles in sleep-to-standby and T_SB2A cycles in standby-to-active before it reads active.
- R7: An access to a bank in standby moves it to standby-to-active for T_SB2A cycles and then to active, with no pump stage.
- R8: An access to a bank that is not active raises that bank's wait flag. The flag stays high until the bank reads active and falls in that same cycle.
- R9: Ready is 1 exactly when the pump and every bank read active.
- R10: A wake request that arrives while active banks are counting down cancels the entry. The banks stay active and restart their counts. The request stays pending until ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_acc | input | NB | Per-bank access strobe, bit i for bank i |
| bank_fb | input | 2*NB | Per-bank fall-back code (0 active, 1 standby, 2/3 sleep), bits 2i+1:2i for bank i |
| pump_fb_sleep | input | 1 | Pump fall-back: 1 allows pump sleep |
| grace | input | GW | Idle grace period in cycles |
| wake_req | input | 1 | Wake request pulse |
| bank_st | output | 3*NB | Per-bank state code, bits 3i+2:3i for bank i |
| pump_st | output | 2 | Pump state code |
| bank_wait | output | NB | Per-bank wait flag |
| ready | output | 1 | Pump and all banks active |

## Verification
The sequence tests start with all fall-backs set to active. This separates "idle but held active" from a real countdown. Next comes a full sleep entry on both banks, then a wake by access to a single bank, which exercises the pump stage while the other bank stays asleep. A global wake request then brings both banks back in lockstep.

A standby fall-back on one bank shows the short wake path, with no pump stage. A wake request in the middle of a countdown shows that the entry is cancelled: the banks are still active at the cycle where they would otherwise have slept. Directed cases cover the reset values, a zero grace period, and the exact cycle at which a wait flag drops after a full wake from sleep.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [2:0] {
        BK_ACT  = 3'd0,
        BK_STBY = 3'd1,
        BK_SLP  = 3'd2,
        BK_S2SB = 3'd3,
        BK_SB2A = 3'd4
    } bank_st_e;

    typedef enum logic [1:0] {
        PM_ACT  = 2'd0,
        PM_SLP  = 2'd1,
        PM_WAKE = 2'd2
    } pump_st_e;

    typedef enum logic [1:0] {
        FB_ACT  = 2'd0,
        FB_STBY = 2'd1,
        FB_SLP  = 2'd2,
        FB_SLP2 = 2'd3
    } fb_e;

    // Inputs seen by one bank in a cycle
    typedef struct packed {
        logic acc;
        logic wake;
        fb_e  fb;
    } bank_req_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic fb_is_low(input fb_e f);
        return f != FB_ACT;
    endfunction

endpackage

// File: rtl/fps_bank.sv
module fps_bank
    import fps_pkg::*;
#(
    parameter int GW     = 8,
    parameter int CW     = 8,
    parameter int T_S2SB = 3,
    parameter int T_SB2A = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  bank_req_t       req,
    input  logic [GW-1:0]   grace,
    input  logic            pump_act,
    output logic [2:0]      st_o,
    output logic            wait_o,
    output logic            need_pump_o
);

    bank_st_e       st_q, st_n;
    logic [CW-1:0]  cnt_q, cnt_n;
    logic           pend_q, pend_n;
    logic           wait_q;
    logic           poke;

    assign poke = req.acc | req.wake;

    always_comb begin
        st_n   = st_q;
        cnt_n  = cnt_q;
        pend_n = pend_q;
        unique case (st_q)
            BK_ACT: begin
                if (poke)
                    cnt_n = CW'(grace);
                else if (cnt_q != '0)
                    cnt_n = cnt_q - 1'b1;
                else if (fb_is_low(req.fb))
                    st_n = (req.fb == FB_STBY) ? BK_STBY : BK_SLP;
            end
            BK_STBY: begin
                if (poke) begin
                    st_n  = BK_SB2A;
                    cnt_n = CW'(T_SB2A - 1);
                end
            end
            BK_SLP: begin
                pend_n = pend_q | poke;
                if ((pend_q | poke) && pump_act) begin
                    st_n   = BK_S2SB;
                    cnt_n  = CW'(T_S2SB - 1);
                    pend_n = 1'b0;
                end
            end
            BK_S2SB: begin
                if (cnt_q == '0) begin
                    st_n  = BK_SB2A;
                    cnt_n = CW'(T_SB2A - 1);
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            BK_SB2A: begin
                if (cnt_q == '0) begin
                    st_n  = BK_ACT;
                    cnt_n = CW'(grace);
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            default: st_n = BK_ACT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= BK_ACT;
            cnt_q  <= CW'(grace);
            pend_q <= 1'b0;
            wait_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            pend_q <= pend_n;
            wait_q <= (wait_q | (req.acc && st_q != BK_ACT)) && (st_n != BK_ACT);
        end
    end

    assign st_o        = st_q;
    assign wait_o      = wait_q | (req.acc && st_q != BK_ACT);
    assign need_pump_o = (st_q == BK_SLP) && (pend_q | poke);

    // R2: leaving active only follows an idle edge
    p_leave_idle_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == BK_ACT && st_q != BK_ACT) |-> (!$past(req.acc) && !$past(req.wake)));

    // R3: an access holds an active bank active
    p_reload_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == BK_ACT && req.acc) |=> (st_q == BK_ACT));

    // R10: a wake during countdown aborts the entry
    p_abort_entry_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == BK_ACT && req.wake) |=> (st_q == BK_ACT));

    // R5: sleep exit only with the pump active
    p_exit_needs_pump_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == BK_SLP && st_q == BK_S2SB) |-> $past(pump_act));

    // R6: sleep-to-standby stage only moves forward to standby-to-active
    p_stage_order_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == BK_S2SB) |=> (st_q == BK_S2SB || st_q == BK_SB2A));

    // R7: standby only leaves toward active through its stage
    p_stby_path_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == BK_STBY) |=> (st_q == BK_STBY || st_q == BK_SB2A));

    // R8: an access to a non-active bank keeps wait until active
    p_wait_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q != BK_ACT && req.acc) |=> (wait_o || st_q == BK_ACT));

endmodule

// File: rtl/fps_pump.sv
module fps_pump
    import fps_pkg::*;
#(
    parameter int T_PUMP = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fb_sleep,
    input  logic       all_sleep,
    input  logic       need,
    output logic [1:0] st_o
);

    localparam int PW = $clog2(T_PUMP + 1);

    pump_st_e       st_q;
    logic [PW-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PM_ACT;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                PM_ACT: begin
                    if (fb_sleep && all_sleep && !need)
                        st_q <= PM_SLP;
                end
                PM_SLP: begin
                    if (need) begin
                        st_q  <= PM_WAKE;
                        cnt_q <= PW'(T_PUMP - 1);
                    end
                end
                PM_WAKE: begin
                    if (cnt_q == '0)
                        st_q <= PM_ACT;
                    else
                        cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= PM_ACT;
            endcase
        end
    end

    assign st_o = st_q;

    // R4: pump sleeps only after all banks were asleep
    p_pump_after_banks_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == PM_ACT && st_q == PM_SLP) |-> $past(all_sleep));

    // R5: waking holds until its count runs out
    p_wake_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == PM_WAKE && cnt_q != '0) |=> (st_q == PM_WAKE));

endmodule

// File: rtl/flash_pwr_seq.sv
module flash_pwr_seq
    import fps_pkg::*;
#(
    parameter int NB     = 2,
    parameter int GW     = 8,
    parameter int T_PUMP = 4,
    parameter int T_S2SB = 3,
    parameter int T_SB2A = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NB-1:0]   bank_acc,
    input  logic [2*NB-1:0] bank_fb,
    input  logic            pump_fb_sleep,
    input  logic [GW-1:0]   grace,
    input  logic            wake_req,
    output logic [3*NB-1:0] bank_st,
    output logic [1:0]      pump_st,
    output logic [NB-1:0]   bank_wait,
    output logic            ready
);

    localparam int TMAX = max_int(T_S2SB, T_SB2A);
    localparam int DW   = $clog2(TMAX + 1);
    localparam int CW   = max_int(GW, DW);

    logic            wk_pend_q;
    logic            wake_eff;
    logic            pump_act;
    logic [NB-1:0]   need_vec, sleep_vec, act_vec, s2sb_vec;

    assign wake_eff = wake_req | wk_pend_q;
    assign pump_act = (pump_st == PM_ACT);

    for (genvar i = 0; i < NB; i++) begin : g_bank
        bank_req_t  rq;
        logic [2:0] st;
        assign rq.acc  = bank_acc[i];
        assign rq.wake = wake_eff;
        assign rq.fb   = fb_e'(bank_fb[2*i +: 2]);

        fps_bank #(
            .GW(GW), .CW(CW), .T_S2SB(T_S2SB), .T_SB2A(T_SB2A)
        ) u_bank (
            .clk(clk), .rst(rst), .req(rq), .grace(grace),
            .pump_act(pump_act), .st_o(st), .wait_o(bank_wait[i]),
            .need_pump_o(need_vec[i])
        );

        assign bank_st[3*i +: 3] = st;
        assign sleep_vec[i]      = (st == BK_SLP);
        assign act_vec[i]        = (st == BK_ACT);
        assign s2sb_vec[i]       = (st == BK_S2SB);
    end

    fps_pump #(.T_PUMP(T_PUMP)) u_pump (
        .clk(clk), .rst(rst), .fb_sleep(pump_fb_sleep),
        .all_sleep(&sleep_vec), .need(wake_eff | (|need_vec)),
        .st_o(pump_st)
    );

    assign ready = pump_act && (&act_vec);

    always_ff @(posedge clk) begin
        if (rst) wk_pend_q <= 1'b0;
        else     wk_pend_q <= wake_req | (wk_pend_q & ~ready);
    end

    // R5: no bank is past sleep unless the pump is active
    p_pump_first_r5: assert property (@(posedge clk) disable iff (rst)
        (|s2sb_vec) |-> (pump_st == PM_ACT));

    // R10: a request stays pending until ready is seen
    p_wake_latched_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(wake_req) && !$past(ready)) |-> wk_pend_q);

endmodule

// File: tb/sim_flash_pwr_seq.sv
module sim_flash_pwr_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bank_acc = '0;
    logic [3:0] bank_fb = '0;
    logic       pump_fb_sleep = 1'b0;
    logic [7:0] grace = 8'd3;
    logic       wake_req = 1'b0;
    logic [5:0] bank_st;
    logic [1:0] pump_st;
    logic [1:0] bank_wait;
    logic       ready;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flash_pwr_seq #(.NB(2), .GW(8), .T_PUMP(4), .T_S2SB(3), .T_SB2A(2)) u0 (
        .clk(clk), .rst(rst), .bank_acc(bank_acc), .bank_fb(bank_fb),
        .pump_fb_sleep(pump_fb_sleep), .grace(grace), .wake_req(wake_req),
        .bank_st(bank_st), .pump_st(pump_st), .bank_wait(bank_wait), .ready(ready)
    );

    // observed = {bank0 state, bank1 state, pump state, wait[1:0], ready}
    typedef struct packed {
        logic [1:0]  acc;
        logic [1:0]  fb0;
        logic [1:0]  fb1;
        logic        pfb;
        logic        wk;
        logic [7:0]  n;
        logic [10:0] exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t TBL [0:NV-1] = '{
        {2'b00, 2'd0, 2'd0, 1'b0, 1'b0, 8'd5, {3'd0, 3'd0, 2'd0, 2'b00, 1'b1}, 4'd3},  // R3 fb active
        {2'b11, 2'd2, 2'd2, 1'b1, 1'b0, 8'd4, {3'd0, 3'd0, 2'd0, 2'b00, 1'b1}, 4'd2},  // R2 counting
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd1, {3'd2, 3'd2, 2'd0, 2'b00, 1'b0}, 4'd2},  // R2 sleep edge
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd1, {3'd2, 3'd2, 2'd1, 2'b00, 1'b0}, 4'd4},  // R4 pump sleeps
        {2'b01, 2'd2, 2'd2, 1'b1, 1'b0, 8'd1, {3'd2, 3'd2, 2'd2, 2'b01, 1'b0}, 4'd5},  // R5 access wakes pump
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd3, {3'd2, 3'd2, 2'd2, 2'b01, 1'b0}, 4'd5},  // R5 still waking
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd1, {3'd2, 3'd2, 2'd0, 2'b01, 1'b0}, 4'd5},  // R5 pump active
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd1, {3'd3, 3'd2, 2'd0, 2'b01, 1'b0}, 4'd6},  // R6 to standby stage
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd2, {3'd3, 3'd2, 2'd0, 2'b01, 1'b0}, 4'd6},  // R6
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd1, {3'd4, 3'd2, 2'd0, 2'b01, 1'b0}, 4'd6},  // R6 to active stage
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd1, {3'd4, 3'd2, 2'd0, 2'b01, 1'b0}, 4'd8},  // R8 wait held
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd1, {3'd0, 3'd2, 2'd0, 2'b00, 1'b0}, 4'd9},  // R9 one bank asleep
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd3, {3'd0, 3'd2, 2'd0, 2'b00, 1'b0}, 4'd4},  // R4 pump holds
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd1, {3'd2, 3'd2, 2'd0, 2'b00, 1'b0}, 4'd2},  // R2
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd1, {3'd2, 3'd2, 2'd1, 2'b00, 1'b0}, 4'd4},  // R4
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b1, 8'd1, {3'd2, 3'd2, 2'd2, 2'b00, 1'b0}, 4'd5},  // R5 wake request
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd4, {3'd2, 3'd2, 2'd0, 2'b00, 1'b0}, 4'd5},  // R5
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd1, {3'd3, 3'd3, 2'd0, 2'b00, 1'b0}, 4'd6},  // R6
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd3, {3'd4, 3'd4, 2'd0, 2'b00, 1'b0}, 4'd6},  // R6
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd2, {3'd0, 3'd0, 2'd0, 2'b00, 1'b1}, 4'd9},  // R9 all ready
        {2'b11, 2'd1, 2'd0, 1'b0, 1'b0, 8'd5, {3'd1, 3'd0, 2'd0, 2'b00, 1'b0}, 4'd7},  // R7 to standby
        {2'b01, 2'd1, 2'd0, 1'b0, 1'b0, 8'd1, {3'd4, 3'd0, 2'd0, 2'b01, 1'b0}, 4'd7},  // R7 access
        {2'b00, 2'd1, 2'd0, 1'b0, 1'b0, 8'd1, {3'd4, 3'd0, 2'd0, 2'b01, 1'b0}, 4'd8},  // R8
        {2'b00, 2'd1, 2'd0, 1'b0, 1'b0, 8'd1, {3'd0, 3'd0, 2'd0, 2'b00, 1'b1}, 4'd7},  // R7 active
        {2'b11, 2'd2, 2'd2, 1'b1, 1'b0, 8'd2, {3'd0, 3'd0, 2'd0, 2'b00, 1'b1}, 4'd3},  // R3 reload
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b1, 8'd3, {3'd0, 3'd0, 2'd0, 2'b00, 1'b1}, 4'd10}, // R10 abort
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd3, {3'd2, 3'd2, 2'd0, 2'b00, 1'b0}, 4'd10}, // R10 later sleep
        {2'b00, 2'd2, 2'd2, 1'b1, 1'b0, 8'd1, {3'd2, 3'd2, 2'd1, 2'b00, 1'b0}, 4'd4}   // R4
    };

    function automatic logic [10:0] observe();
        return {bank_st[2:0], bank_st[5:3], pump_st, bank_wait, ready};
    endfunction

    task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b (b0,b1,pump,wait,ready)", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset values
        repeat (2) @(negedge clk);
        check("R1", observe(), {3'd0, 3'd0, 2'd0, 2'b00, 1'b1});
        rst = 1'b0;
        @(negedge clk);
        check("R1", observe(), {3'd0, 3'd0, 2'd0, 2'b00, 1'b1});

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = TBL[i];
            bank_acc      = v.acc;
            bank_fb       = {v.fb1, v.fb0};
            pump_fb_sleep = v.pfb;
            wake_req      = v.wk;
            @(negedge clk);
            bank_acc = '0;
            wake_req = 1'b0;
            for (int k = 1; k < int'(v.n); k++) @(negedge clk);
            check($sformatf("R%0d row%0d", v.rq, i), observe(), v.exp);
        end

        // R2: zero grace, taken from reset
        rst = 1'b1;
        grace = 8'd0;
        bank_fb = {2'd2, 2'd2};
        pump_fb_sleep = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset again", observe(), {3'd0, 3'd0, 2'd0, 2'b00, 1'b1});
        rst = 1'b0;
        @(negedge clk);
        check("R2 zero grace", observe(), {3'd2, 3'd2, 2'd0, 2'b00, 1'b0});
        @(negedge clk);
        check("R4 pump after banks", observe(), {3'd2, 3'd2, 2'd1, 2'b00, 1'b0});

        // R8/R6: wait on bank1 drops after 4 pump + 1 + 3 + 2 + 1 edges
        bank_acc = 2'b10;
        @(negedge clk);
        bank_acc = '0;
        check("R8 wait raised", {8'd0, 1'b0, bank_wait}, {8'd0, 1'b0, 2'b10});
        for (int k = 1; k < 10; k++) @(negedge clk);
        check("R6 bank1 in last stage", {8'd0, bank_st[5:3]}, {8'd0, 3'd4});
        check("R8 wait still high", {9'd0, bank_wait}, {9'd0, 2'b10});
        @(negedge clk);
        check("R8 wait falls at active", {bank_st[2:0], bank_st[5:3], pump_st, bank_wait, 1'b0},
              {3'd2, 3'd0, 2'd0, 2'b00, 1'b0});

        done = 1'b1;
        finish_run();
    end

endmodule